// File: doc/BRIEF.md
# Three-Level Nesting Interrupt Controller

The controller watches ten level-sensitive interrupt request lines. Each line has a one-bit urgency select that picks between the low level and that line's elevated level. For lines 0 and 1 the elevated level is the top level. For lines 2 to 9 it is the high level. A line can therefore never be given a level it is not allowed to use. Levels are ordered top above high above low.

The controller keeps a record of the levels now in service, so interrupts can nest. It offers a request to the processor only when the request's level is strictly above the level in service. When nothing is in service, a request at any level is offered.

When several eligible requests are present, the controller picks the one at the highest level. Among equal levels it picks the lowest line number, which is also the smallest vector address. The chosen vector address and a pending flag are registered, and they stay fixed until the processor acknowledges. The acknowledge records the granted level as the new service level. A return strobe drops back to the level that was in service before.

The sequencer has two states.
- SCAN searches for an eligible request every cycle. It moves to OFFER on the edge where a winner is found, and the winning vector and level are captured on that same edge.
- OFFER holds the pending flag and the vector. It moves back to SCAN on an acknowledge.
- The return strobe is honoured in both states.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_pend` is 0, `irq_vec` is 0 and `cur_lvl` is 0 (nothing in service).
- R2: `cur_lvl` encodes 0 = none, 1 = low, 2 = high, 3 = top. A line whose `irq_hi` bit is 0 requests low. With the bit at 1, lines 0 and 1 request top and lines 2 to 9 request high.
- R3: The vector address for line i is 0x03 + 8*i, so it runs from 0x03 for line 0 to 0x4B for line 9.
- R4: With nothing in service, an asserted request at any level is offered. `irq_pend` rises on the clock edge that follows the cycle in which the request is first sampled.
- R5: When eligible requests at different levels are present together, the one at the highest level is offered.
- R6: When several eligible requests share the highest level present, the one on the lowest line number is offered.
- R7: A request whose level is equal to or below `cur_lvl` is not offered while that level stays in service.
- R8: While `irq_pend` is 1 and `ack` is 0, `irq_pend` and `irq_vec` hold, even if a more urgent request appears. On an `ack` while `irq_pend` is 1, `irq_pend` falls on that edge and `cur_lvl` becomes the granted level.
- R9: A `reti` pulse restores `cur_lvl` to the level that was in service before the most recent grant. A `reti` with nothing in service has no effect.
- R10: An `ack` while `irq_pend` is 0 has no effect on `cur_lvl` or `irq_pend`.
- R11: Grants nest up to three deep (low, then high, then top), and returns unwind them in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 10 | Level-sensitive request per line |
| irq_hi | input | 10 | Per-line urgency select: 0 = low, 1 = the line's elevated level |
| ack | input | 1 | Processor takes the offered vector |
| reti | input | 1 | Processor leaves the current handler |
| irq_pend | output | 1 | A vector is on offer |
| irq_vec | output | 7 | Offered vector address |
| cur_lvl | output | 2 | Level now in service |

## Verification
The assertions take for granted that the processor never raises `ack` and `reti` in the same cycle. They also assume `reti` is given only when there is a handler to leave. Under those assumptions, every grant strictly raises the service level and every return strictly lowers it.

The stimulus drives single-cycle `ack` and `reti` pulses, never both together. It issues returns only against levels it has granted, apart from one deliberate return with nothing in service. It holds requests until their handlers have been acknowledged, as a source that clears its own request would do.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_t;

    typedef enum logic {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } seq_state_t;

    localparam int NUM_LEVELS = 3;

endpackage

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
    import irq_nest_pkg::*;
#(
    parameter int NUM_VEC = 10,
    parameter int NUM_TOP = 2,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] req,
    input  logic [NUM_VEC-1:0] hi,
    input  lvl_t               cur,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx,
    output lvl_t               win_lvl
);

    logic [1:0] line_lvl [NUM_VEC];

    // Elevated level depends on the line position.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_line
        if (g < NUM_TOP) begin : g_top
            assign line_lvl[g] = hi[g] ? 2'(LVL_TOP) : 2'(LVL_LOW);
        end else begin : g_high
            assign line_lvl[g] = hi[g] ? 2'(LVL_HIGH) : 2'(LVL_LOW);
        end
    end

    // Highest level first, lowest line within a level.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = LVL_NONE;
        for (int l = NUM_LEVELS; l >= 1; l--) begin
            if (!found && (l[1:0] > 2'(cur))) begin
                for (int i = 0; i < NUM_VEC; i++) begin
                    if (!found && req[i] && (line_lvl[i] == l[1:0])) begin
                        found   = 1'b1;
                        win_idx = i[IDX_W-1:0];
                        win_lvl = lvl_t'(l[1:0]);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import irq_nest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  lvl_t push_lvl,
    input  logic pop,
    output lvl_t cur
);

    // One bit per level in service; grants strictly rise, so the highest
    // set bit is the top of the nesting record.
    logic [NUM_LEVELS:1] in_svc_q;
    logic [NUM_LEVELS:1] in_svc_d;

    always_comb begin
        cur = LVL_NONE;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (in_svc_q[l]) cur = lvl_t'(l[1:0]);
        end
    end

    always_comb begin
        in_svc_d = in_svc_q;
        if (pop && (cur != LVL_NONE)) in_svc_d[cur] = 1'b0;
        if (push && (push_lvl != LVL_NONE)) in_svc_d[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_svc_q <= '0;
        else        in_svc_q <= in_svc_d;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_VEC  = 10,
    parameter int NUM_TOP  = 2,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    parameter int ADDR_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic [NUM_VEC-1:0] irq_hi,
    input  logic               ack,
    input  logic               reti,
    output logic               irq_pend,
    output logic [ADDR_W-1:0]  irq_vec,
    output logic [1:0]         cur_lvl
);

    localparam int IDX_W = $clog2(NUM_VEC);

    seq_state_t state_q, state_d;
    lvl_t       cur;
    lvl_t       win_lvl, lvl_q;
    logic       found;
    logic [IDX_W-1:0]  win_idx;
    logic [ADDR_W-1:0] vec_q;
    logic              grant;

    irq_nest_arb #(
        .NUM_VEC(NUM_VEC),
        .NUM_TOP(NUM_TOP),
        .IDX_W  (IDX_W)
    ) u_arb (
        .req    (irq_req),
        .hi     (irq_hi),
        .cur    (cur),
        .found  (found),
        .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    assign grant = (state_q == ST_OFFER) && ack;

    irq_nest_stack u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (grant),
        .push_lvl(lvl_q),
        .pop     (reti),
        .cur     (cur)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:  if (found) state_d = ST_OFFER;
            ST_OFFER: if (ack)   state_d = ST_SCAN;
            default:             state_d = ST_SCAN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // Offer registers: captured only on the SCAN-to-OFFER edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= LVL_NONE;
        end else if ((state_q == ST_SCAN) && found) begin
            vec_q <= ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
            lvl_q <= win_lvl;
        end
    end

    assign irq_pend = (state_q == ST_OFFER);
    assign irq_vec  = vec_q;
    assign cur_lvl  = 2'(cur);

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int NUM_VEC  = 10,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    parameter int ADDR_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              reti,
    input logic              irq_pend,
    input logic [ADDR_W-1:0] irq_vec,
    input logic [1:0]        cur_lvl
);

    localparam int VEC_LAST = VEC_BASE + VEC_STEP * (NUM_VEC - 1);

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend && !ack |=> irq_pend && $stable(irq_vec)); // R8

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend && ack |=> !irq_pend); // R8

    AST_GRANT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend && ack && !reti |=> cur_lvl > $past(cur_lvl)); // R7

    AST_VEC_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> (int'(irq_vec) >= VEC_BASE) && (int'(irq_vec) <= VEC_LAST)
                     && (((int'(irq_vec) - VEC_BASE) % VEC_STEP) == 0)); // R3

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pend && (cur_lvl == 2'd0) |=> cur_lvl == 2'd0); // R10

    AST_RETURN_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        reti && !ack && (cur_lvl != 2'd0) |=> cur_lvl < $past(cur_lvl)); // R9

    AST_LEVEL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !reti && !(irq_pend && ack) |=> $stable(cur_lvl)); // R11

endmodule

bind irq_nest_ctrl irq_nest_chk #(
    .NUM_VEC (NUM_VEC),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .reti    (reti),
    .irq_pend(irq_pend),
    .irq_vec (irq_vec),
    .cur_lvl (cur_lvl)
);

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] irq_req;
    logic [9:0] irq_hi;
    logic       ack;
    logic       reti;
    logic       irq_pend;
    logic [6:0] irq_vec;
    logic [1:0] cur_lvl;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_hi(irq_hi),
        .ack(ack), .reti(reti), .irq_pend(irq_pend), .irq_vec(irq_vec),
        .cur_lvl(cur_lvl)
    );

    // Behavioural reference model
    int m_stack[$];
    bit m_pend;
    int m_vec;
    int m_lvl;

    function automatic int want_level(int i, bit h);
        if (!h) return 1;
        return (i < 2) ? 3 : 2;
    endfunction

    function automatic int model_cur();
        if (m_stack.size() == 0) return 0;
        return m_stack[m_stack.size()-1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stack.delete();
            m_pend = 0;
            m_vec  = 0;
            m_lvl  = 0;
        end else begin
            int cur_now;
            bit hit;
            cur_now = model_cur();
            hit = 0;
            if (!m_pend) begin
                for (int lv = 3; lv > cur_now; lv--) begin
                    for (int i = 0; i < 10; i++) begin
                        if (!hit && irq_req[i] && want_level(i, irq_hi[i]) == lv) begin
                            hit = 1;
                            m_pend = 1;
                            m_vec = 3 + 8 * i;
                            m_lvl = lv;
                        end
                    end
                end
            end else if (ack) begin
                m_stack.push_back(m_lvl);
                m_pend = 0;
            end
            if (reti && m_stack.size() > 0) void'(m_stack.pop_back());
        end
    end

    task automatic check(string tag, string what, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // One clock; compare against the model away from the edge.
    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, "pend", int'(irq_pend), int'(m_pend));
        check(tag, "vec", int'(irq_vec), m_vec);
        check(tag, "level", int'(cur_lvl), model_cur());
    endtask

    task automatic pulse_ack(string tag);
        ack = 1'b1; tick(tag); ack = 1'b0;
    endtask

    task automatic pulse_reti(string tag);
        reti = 1'b1; tick(tag); reti = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; irq_hi = '0; ack = 1'b0; reti = 1'b0;
        @(negedge clk);
        tick("R1"); tick("R1");
        check("R1", "pend", int'(irq_pend), 0);
        check("R1", "level", int'(cur_lvl), 0);
        check("R1", "vec", int'(irq_vec), 0);
        rst_n = 1'b1;
        tick("R1");

        // Single low request on line 5, held without ack
        irq_req[5] = 1'b1;
        tick("R4");
        check("R3", "vec line5", int'(irq_vec), 8'h2B);
        check("R4", "pend", int'(irq_pend), 1);
        tick("R8"); tick("R8"); tick("R8");
        pulse_ack("R8");
        check("R2", "level after low grant", int'(cur_lvl), 1);
        tick("R7"); tick("R7");
        check("R7", "pend same level", int'(irq_pend), 0);
        irq_req[5] = 1'b0;

        // Return, empty return, stray ack
        pulse_reti("R9");
        check("R9", "level after return", int'(cur_lvl), 0);
        pulse_reti("R9");
        check("R9", "empty return", int'(cur_lvl), 0);
        pulse_ack("R10");
        check("R10", "stray ack level", int'(cur_lvl), 0);
        check("R10", "stray ack pend", int'(irq_pend), 0);

        // Mixed levels: low line 3, high line 7
        irq_req[3] = 1'b1;
        irq_req[7] = 1'b1; irq_hi[7] = 1'b1;
        tick("R5");
        check("R5", "high wins", int'(irq_vec), 8'h3B);
        pulse_ack("R5");
        check("R2", "high level", int'(cur_lvl), 2);
        tick("R7"); tick("R7");
        // Top request on line 0 nests over high
        irq_req[0] = 1'b1; irq_hi[0] = 1'b1;
        tick("R11");
        check("R11", "top offered", int'(irq_vec), 8'h03);
        pulse_ack("R11");
        check("R11", "three deep", int'(cur_lvl), 3);
        irq_req[1] = 1'b1; irq_hi[1] = 1'b1;
        tick("R7");
        check("R7", "equal top refused", int'(irq_pend), 0);
        pulse_reti("R9");
        check("R9", "back to high", int'(cur_lvl), 2);
        tick("R6");
        check("R6", "lowest top line", int'(irq_vec), 8'h03);
        irq_req[0] = 1'b0; irq_req[1] = 1'b0;
        pulse_ack("R6");
        pulse_reti("R11");
        pulse_reti("R11");
        check("R11", "unwound to low-eligible", int'(cur_lvl), 0);
        tick("R4");
        pulse_ack("R4");
        irq_req[7] = 1'b0; irq_req[3] = 1'b0; irq_hi = '0;
        pulse_reti("R9");
        tick("R9");

        // Same-level tie among high lines 9, 4, 2
        irq_req[9] = 1'b1; irq_req[4] = 1'b1; irq_req[2] = 1'b1;
        irq_hi[9] = 1'b1; irq_hi[4] = 1'b1; irq_hi[2] = 1'b1;
        tick("R6");
        check("R6", "lowest high line", int'(irq_vec), 8'h13);
        pulse_ack("R6");
        irq_req = '0; irq_hi = '0;
        pulse_reti("R6");

        // Line 1 with select clear is low, not top
        irq_req[1] = 1'b1;
        tick("R2");
        pulse_ack("R2");
        check("R2", "line1 low", int'(cur_lvl), 1);
        irq_req[1] = 1'b0;
        pulse_reti("R2");

        // Every line's vector
        for (int i = 0; i < 10; i++) begin
            irq_req[i] = 1'b1;
            irq_hi[i]  = i[0];
            tick("R3");
            check("R3", "vector sweep", int'(irq_vec), 3 + 8 * i);
            pulse_ack("R3");
            irq_req[i] = 1'b0;
            pulse_reti("R3");
            tick("R3");
        end
        irq_hi = '0;

        // Offer is not pre-empted by a later, more urgent request
        irq_req[6] = 1'b1;
        tick("R8");
        irq_req[8] = 1'b1; irq_hi[8] = 1'b1;
        tick("R8"); tick("R8");
        check("R8", "held vector", int'(irq_vec), 8'h33);
        pulse_ack("R8");
        irq_req[6] = 1'b0;
        tick("R8");
        check("R8", "high follows", int'(irq_vec), 8'h43);
        pulse_ack("R8");
        irq_req[8] = 1'b0; irq_hi = '0;
        pulse_reti("R9"); pulse_reti("R9");

        // Return arriving while an offer is open
        irq_req[2] = 1'b1; irq_hi[2] = 1'b1;
        tick("R9"); pulse_ack("R9");
        irq_req[2] = 1'b0;
        irq_req[0] = 1'b1; irq_hi[0] = 1'b1;
        tick("R9");
        pulse_reti("R9");
        check("R9", "pop during offer", int'(cur_lvl), 0);
        pulse_ack("R9");
        irq_req = '0; irq_hi = '0;
        pulse_reti("R9");
        tick("R9");

        done = 1;
        finish_run();
    end

endmodule